// File: doc/BRIEF.md
# Bus Node Error Counter with Bus-Off Recovery

This block keeps the transmit and receive error tallies of a serial bus node and derives from them the warning, error-passive and bus-off conditions. Upstream logic detects the errors. It hands this block one-cycle strobes: a transmitted frame failed, a received frame failed, or a frame completed cleanly. The block adjusts the two counters and updates its flags in the same clock edge.

When the transmit tally passes the bus-off limit, the node takes itself off the bus. It raises the bus-off flag and forces its init-control bit high. It then waits for software to clear that bit. Once the bit is clear, the block watches the sampled receive line at each bit-time enable. It counts runs of eleven consecutive recessive bits. Each finished run writes code 5 into the last-error-code field and raises a status pulse. After the 128th run, the node clears bus-off and both counters and resumes normal operation. Flag changes are reported as single-cycle pulses to an interrupt controller.

Top module: `bus_err_tracker`

## Requirements
- R1: Outside bus-off, each transmit-error strobe adds 8 to the transmit counter. A transmit error takes precedence over a success strobe in the same cycle.
- R2: Outside bus-off, each receive-error strobe adds 1 to the receive counter unless the node is error passive. While passive, the receive counter does not increase.
- R3: A success strobe subtracts 1 from each counter that is nonzero and has no error strobe in the same cycle. A counter at zero stays at zero.
- R4: The warning flag is 1 exactly when either counter is at least 96. The error-passive output is 1 exactly when either counter is at least 128.
- R5: When the transmit counter would exceed 255, the block does three things in that same edge: it sets bus-off, it forces the init bit to 1, and it lets the counter take the new value. While bus-off is set, error and success strobes leave both counters unchanged.
- R6: A software write strobe loads the init bit with the supplied value. The init bit is 1 after reset. Recovery runs only while bus-off is 1 and the init bit is 0. Recessive bits seen while the init bit is 1 produce no status pulse.
- R7: During recovery, the receive line is sampled only on a bit-time enable, with 1 meaning recessive. Eleven consecutive recessive samples complete a run. A completed run writes 5 into the 3-bit last-error-code field and raises the status pulse for exactly one cycle.
- R8: A dominant sample during recovery restarts the eleven-bit count. It keeps the number of runs already completed.
- R9: Completing the 128th run clears bus-off and resets both counters to zero in the same edge.
- R10: Whenever the warning flag or the bus-off flag changes, the error-change pulse is 1 for the cycle in which the new flag value is first visible. At all other times it is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tx_err_i | input | 1 | Transmitted frame failed (one-cycle strobe) |
| rx_err_i | input | 1 | Received frame failed (one-cycle strobe) |
| ok_i | input | 1 | Frame completed without error (one-cycle strobe) |
| bit_en_i | input | 1 | Bit-time enable for the receive-line sample |
| rx_bit_i | input | 1 | Sampled receive line, 1 = recessive |
| init_wr_i | input | 1 | Software write strobe for the init bit |
| init_val_i | input | 1 | Value written to the init bit |
| tec_o | output | 9 | Transmit error counter |
| rec_o | output | 9 | Receive error counter |
| warn_o | output | 1 | Warning flag |
| passive_o | output | 1 | Error-passive state |
| busoff_o | output | 1 | Bus-off flag |
| init_o | output | 1 | Init-control bit (forced to 1 on bus-off) |
| lec_o | output | 3 | Last-error-code field |
| status_evt_o | output | 1 | Status-change pulse |
| err_evt_o | output | 1 | Error-flag change pulse |

## Verification
The hardest state to reach from the ports is the final edge of recovery. It lies behind 32 transmit errors, a software write of the init bit, and 1408 sampled bits. The bench drives the transmit counter straight to the bus-off limit. It confirms that recessive bits do nothing until the init bit is cleared. It then interrupts the first run with a dominant bit just before the run would finish. A bit-feeding task streams the remaining runs, counts the status pulses, and stops one bit short of the end, so the last edge can be checked in isolation.

// File: rtl/bec_pkg.sv
package bec_pkg;
    localparam int LEC_W = 3;
    localparam logic [LEC_W-1:0] LEC_RECOVER_RUN = 3'd5;

    typedef struct packed {
        logic             busoff;
        logic             init;
        logic             warn;
        logic [LEC_W-1:0] lec;
        logic             status_evt;
        logic             err_evt;
    } node_state_t;
endpackage

// File: rtl/bec_err_counter.sv
module bec_err_counter #(
    parameter int W   = 9,
    parameter int INC = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en_i,
    input  logic         inc_i,
    input  logic         hold_i,
    input  logic         dec_i,
    input  logic         clr_i,
    output logic [W-1:0] cnt_o,
    output logic [W-1:0] nxt_o
);
    localparam logic [W-1:0] MAX_V  = '1;
    localparam logic [W-1:0] STEP_V = W'(INC);

    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clr_i) begin
            cnt_d = '0;
        end else if (en_i) begin
            if (inc_i) begin
                if (!hold_i) begin
                    cnt_d = (cnt_q > MAX_V - STEP_V) ? MAX_V : cnt_q + STEP_V;
                end
            end else if (dec_i && cnt_q != '0) begin
                cnt_d = cnt_q - 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign cnt_o = cnt_q;
    assign nxt_o = cnt_d;

    // R2
    hold_no_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && inc_i && hold_i && !clr_i) |=> (cnt_q == $past(cnt_q)));

    // R3
    floor_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && dec_i && !inc_i && !clr_i && cnt_q == '0) |=> (cnt_q == '0));

    // R5
    frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_i && !clr_i) |=> (cnt_q == $past(cnt_q)));
endmodule

// File: rtl/bec_recovery.sv
module bec_recovery #(
    parameter int RUN_LEN = 11,
    parameter int RUNS    = 128
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear_i,
    input  logic active_i,
    input  logic bit_en_i,
    input  logic recessive_i,
    output logic run_done_o,
    output logic all_done_o
);
    localparam int RW = $clog2(RUN_LEN);
    localparam int SW = $clog2(RUNS);
    localparam logic [RW-1:0] RUN_LAST = RW'(RUN_LEN - 1);
    localparam logic [SW-1:0] SEQ_LAST = SW'(RUNS - 1);

    typedef struct packed {
        logic [RW-1:0] run;
        logic [SW-1:0] seq;
    } rec_state_t;

    rec_state_t st_d, st_q;
    logic run_done, all_done;

    assign run_done = active_i && bit_en_i && recessive_i && (st_q.run == RUN_LAST);
    assign all_done = run_done && (st_q.seq == SEQ_LAST);

    always_comb begin
        st_d = st_q;
        if (clear_i) begin
            st_d = '0;
        end else if (active_i && bit_en_i) begin
            if (!recessive_i) begin
                st_d.run = '0;
            end else if (run_done) begin
                st_d.run = '0;
                st_d.seq = all_done ? '0 : st_q.seq + 1'b1;
            end else begin
                st_d.run = st_q.run + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign run_done_o = run_done;
    assign all_done_o = all_done;

    // R8
    dominant_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (active_i && bit_en_i && !recessive_i && !clear_i)
        |=> (st_q.run == '0 && st_q.seq == $past(st_q.seq)));

    // R7
    run_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.run <= RUN_LAST);
endmodule

// File: rtl/bus_err_tracker.sv
module bus_err_tracker
    import bec_pkg::*;
#(
    parameter int CNT_W       = 9,
    parameter int TX_STEP     = 8,
    parameter int WARN_LIM    = 96,
    parameter int PASSIVE_LIM = 128,
    parameter int BUSOFF_LIM  = 255,
    parameter int RUN_LEN     = 11,
    parameter int RUNS        = 128
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tx_err_i,
    input  logic             rx_err_i,
    input  logic             ok_i,
    input  logic             bit_en_i,
    input  logic             rx_bit_i,
    input  logic             init_wr_i,
    input  logic             init_val_i,
    output logic [CNT_W-1:0] tec_o,
    output logic [CNT_W-1:0] rec_o,
    output logic             warn_o,
    output logic             passive_o,
    output logic             busoff_o,
    output logic             init_o,
    output logic [LEC_W-1:0] lec_o,
    output logic             status_evt_o,
    output logic             err_evt_o
);
    localparam logic [CNT_W-1:0] WARN_V = CNT_W'(WARN_LIM);
    localparam logic [CNT_W-1:0] PASS_V = CNT_W'(PASSIVE_LIM);
    localparam logic [CNT_W-1:0] BOFF_V = CNT_W'(BUSOFF_LIM);

    node_state_t st_d, st_q;
    logic [CNT_W-1:0] tec_q, tec_nxt, rec_q, rec_nxt;
    logic passive, run_done, all_done, rec_active;

    assign passive    = (tec_q >= PASS_V) || (rec_q >= PASS_V);
    assign rec_active = st_q.busoff && !st_q.init;

    bec_err_counter #(.W(CNT_W), .INC(TX_STEP)) u_tx_cnt (
        .clk(clk), .rst_n(rst_n), .en_i(!st_q.busoff), .inc_i(tx_err_i),
        .hold_i(1'b0), .dec_i(ok_i), .clr_i(all_done),
        .cnt_o(tec_q), .nxt_o(tec_nxt)
    );

    bec_err_counter #(.W(CNT_W), .INC(1)) u_rx_cnt (
        .clk(clk), .rst_n(rst_n), .en_i(!st_q.busoff), .inc_i(rx_err_i),
        .hold_i(passive), .dec_i(ok_i), .clr_i(all_done),
        .cnt_o(rec_q), .nxt_o(rec_nxt)
    );

    bec_recovery #(.RUN_LEN(RUN_LEN), .RUNS(RUNS)) u_recov (
        .clk(clk), .rst_n(rst_n), .clear_i(!st_q.busoff), .active_i(rec_active),
        .bit_en_i(bit_en_i), .recessive_i(rx_bit_i),
        .run_done_o(run_done), .all_done_o(all_done)
    );

    always_comb begin
        st_d            = st_q;
        st_d.status_evt = 1'b0;
        if (init_wr_i) st_d.init = init_val_i;
        if (!st_q.busoff && tec_nxt > BOFF_V) begin
            st_d.busoff = 1'b1;
            st_d.init   = 1'b1;
        end
        if (all_done) st_d.busoff = 1'b0;
        if (run_done) begin
            st_d.lec        = LEC_RECOVER_RUN;
            st_d.status_evt = 1'b1;
        end
        st_d.warn    = (tec_nxt >= WARN_V) || (rec_nxt >= WARN_V);
        st_d.err_evt = (st_d.warn != st_q.warn) || (st_d.busoff != st_q.busoff);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q      <= '0;
            st_q.init <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign tec_o        = tec_q;
    assign rec_o        = rec_q;
    assign warn_o       = st_q.warn;
    assign passive_o    = passive;
    assign busoff_o     = st_q.busoff;
    assign init_o       = st_q.init;
    assign lec_o        = st_q.lec;
    assign status_evt_o = st_q.status_evt;
    assign err_evt_o    = st_q.err_evt;

    // R5
    busoff_forces_init_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.busoff) |-> (st_q.init && tec_q > BOFF_V));

    // R9
    recover_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(st_q.busoff) |-> (tec_q == '0 && rec_q == '0));

    // R7
    run_lec_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.status_evt |-> (st_q.lec == LEC_RECOVER_RUN));

    // R6
    no_recover_while_init_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.busoff && st_q.init) |=> !st_q.status_evt);

    // R10
    flag_change_evt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.busoff != $past(st_q.busoff)) |-> st_q.err_evt);

    // R4
    warn_track_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.warn == ((tec_q >= WARN_V) || (rec_q >= WARN_V)));
endmodule

// File: tb/bus_err_tracker_tb.sv
module bus_err_tracker_tb;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tx_err = 0, rx_err = 0, ok = 0, bit_en = 0, rx_bit = 1, init_wr = 0, init_val = 0;
    logic [8:0] tec, rec;
    logic warn, passive, busoff, init, status_evt, err_evt;
    logic [2:0] lec;
    int n_run = 0, n_fail = 0, pulses = 0;
    bit done = 0;

    always #5 clk = ~clk;

    bus_err_tracker u_dut (
        .clk(clk), .rst_n(rst_n), .tx_err_i(tx_err), .rx_err_i(rx_err), .ok_i(ok),
        .bit_en_i(bit_en), .rx_bit_i(rx_bit), .init_wr_i(init_wr), .init_val_i(init_val),
        .tec_o(tec), .rec_o(rec), .warn_o(warn), .passive_o(passive), .busoff_o(busoff),
        .init_o(init), .lec_o(lec), .status_evt_o(status_evt), .err_evt_o(err_evt)
    );

    // {tx, rx, ok, expected tec, expected rec}, applied one per cycle from reset
    localparam logic [20:0] VEC [10] = '{
        {3'b010, 9'd0,  9'd1},
        {3'b010, 9'd0,  9'd2},
        {3'b001, 9'd0,  9'd1},
        {3'b001, 9'd0,  9'd0},
        {3'b001, 9'd0,  9'd0},
        {3'b100, 9'd8,  9'd0},
        {3'b110, 9'd16, 9'd1},
        {3'b001, 9'd15, 9'd0},
        {3'b101, 9'd23, 9'd0},
        {3'b011, 9'd22, 9'd1}
    };

    task automatic chk(input string req, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic step(input logic t, input logic r, input logic o,
                        input logic be, input logic b);
        @(negedge clk);
        tx_err = t; rx_err = r; ok = o; bit_en = be; rx_bit = b;
        @(posedge clk); #1;
        tx_err = 0; rx_err = 0; ok = 0; bit_en = 0; rx_bit = 1;
    endtask

    task automatic feed(input logic b);
        step(0, 0, 0, 1, b);
        if (status_evt) pulses++;
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 0;
        @(negedge clk); rst_n = 1;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (2) @(negedge clk);
        rst_n = 1;
        // reset state (R6 init=1)
        chk("R6 reset init", init, 1);
        chk("R4 reset warn", warn, 0);
        chk("R5 reset busoff", busoff, 0);
        chk("R1 reset tec", tec, 0);
        chk("R2 reset rec", rec, 0);
        chk("R7 reset lec", lec, 0);

        // R1 R2 R3 table walk
        for (int i = 0; i < 10; i++) begin
            step(VEC[i][20], VEC[i][19], VEC[i][18], 0, 1);
            chk("R1 tec vector", tec, int'(VEC[i][17:9]));
            chk("R3 rec vector", rec, int'(VEC[i][8:0]));
        end

        // R4 warning and R10 pulse
        do_reset();
        for (int i = 0; i < 11; i++) step(1, 0, 0, 0, 1);
        chk("R4 warn below 96", warn, 0);
        step(1, 0, 0, 0, 1);
        chk("R4 warn at 96", warn, 1);
        chk("R10 err_evt on warn", err_evt, 1);
        step(0, 0, 0, 0, 1);
        chk("R10 err_evt single", err_evt, 0);
        for (int i = 0; i < 3; i++) step(1, 0, 0, 0, 1);
        chk("R4 passive below 128", passive, 0);
        step(1, 0, 0, 0, 1);
        chk("R4 passive at 128", passive, 1);
        step(0, 1, 0, 0, 1);
        chk("R2 rec frozen passive", rec, 0);

        // R5 bus-off entry
        for (int i = 0; i < 15; i++) step(1, 0, 0, 0, 1);
        chk("R5 tec 248", tec, 248);
        chk("R5 no busoff at 248", busoff, 0);
        step(1, 0, 0, 0, 1);
        chk("R5 busoff set", busoff, 1);
        chk("R5 init forced", init, 1);
        chk("R5 tec 256", tec, 256);
        chk("R10 err_evt on busoff", err_evt, 1);
        step(1, 1, 1, 0, 1);
        chk("R5 tec frozen", tec, 256);
        chk("R5 rec frozen", rec, 0);

        // R6 no recovery while init set
        pulses = 0;
        for (int i = 0; i < 25; i++) feed(1);
        chk("R6 no pulse init=1", pulses, 0);
        chk("R6 lec untouched", lec, 0);
        @(negedge clk); init_wr = 1; init_val = 0;
        @(negedge clk); init_wr = 0;
        chk("R6 init cleared", init, 0);

        // R8 dominant restarts the run
        for (int i = 0; i < 10; i++) feed(1);
        feed(0);
        for (int i = 0; i < 10; i++) feed(1);
        chk("R8 no pulse after restart", pulses, 0);
        feed(1);
        chk("R7 pulse on 11th", status_evt, 1);
        chk("R7 lec 5", lec, 5);
        feed(1);
        chk("R7 pulse one cycle", status_evt, 0);
        for (int i = 0; i < 10; i++) feed(1);
        chk("R8 tally kept", pulses, 2);

        // R9 remaining runs
        for (int r = 0; r < 125; r++)
            for (int i = 0; i < 11; i++) feed(1);
        for (int i = 0; i < 10; i++) feed(1);
        chk("R9 busoff before last", busoff, 1);
        chk("R9 127 pulses", pulses, 127);
        feed(1);
        chk("R9 busoff cleared", busoff, 0);
        chk("R9 tec zero", tec, 0);
        chk("R9 rec zero", rec, 0);
        chk("R10 err_evt on recovery", err_evt, 1);
        chk("R9 128 pulses", pulses, 128);
        step(1, 0, 0, 0, 1);
        chk("R1 counting resumes", tec, 8);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule